// File: doc/BRIEF.md
# Two-Wire Slave with 16-bit Register Bank

This block is a serial slave on a two-wire bus, giving the bus master access to a bank of 256 registers of 16 bits each. The open-drain data line is modelled as an input, `sda_i`, and a pull-low enable, `sda_oe_o`. Both bus lines are oversampled by the system clock. The slave detects start and stop conditions, compares the device address byte and sends acknowledges.

A bus write begins with an address byte that has its direction bit clear. The next byte is a register index. After that, bytes arrive in pairs, high byte first, and each pair fills one register. A bus read starts the same way, with the index byte. The master then issues a repeated start and sends the read-direction address. The slave returns bytes starting from that index, and the index advances after each complete register in both directions. The rest of the chip reads and writes the same bank through a parallel port.

Top module: `twi_reg16_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Both lines pass through a synchronizer and are sampled by a system clock at least 8 times faster than SCL. After a start or a stop the slave has SDA released.
- R2: The first byte after a start carries the address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). Bits 7..1 must equal those of parameter DEV_ADDR (default 0xBA, so 0xBA addresses a write and 0xBB a read). On a match the slave pulls SDA low during the ninth clock.
- R3: After a non-matching address byte the slave leaves SDA released. It acknowledges nothing and writes nothing until the next start.
- R4: In a write transfer the byte after the address is the register index. The slave acknowledges the index byte and every data byte.
- R5: Data bytes pair up high byte first. A register is written only after its low byte has been acknowledged. A high byte that is left without a low byte when a stop or a new start arrives is discarded.
- R6: The register index advances by one after each complete 16-bit value, in writes and in reads alike. It wraps from 0xFF to 0x00.
- R7: After an index write, a repeated start with the read address makes the slave return bytes starting at that index. Each register is sent high byte first, and each byte is sent most significant bit first.
- R8: In a read the slave keeps sending bytes while the master acknowledges them. After a master no-acknowledge the slave releases SDA and stays off the bus until the next start.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: All registers reset to 0. The parallel port writes `host_wdata_i` to register `host_addr_i` in the clock where `host_we_i` is high. `host_rdata_o` shows register `host_addr_i` combinationally.
- R11: A stop or a repeated start ends a write transfer. Registers written before it keep their values, and a later write transfer can begin at a new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low |
| host_we_i | input | 1 | Parallel-port write enable |
| host_addr_i | input | 8 | Parallel-port register index |
| host_wdata_i | input | 16 | Parallel-port write data |
| host_rdata_o | output | 16 | Parallel-port read data |

## Verification
The bench starts a burst write at index 0xFE, so the index must wrap through 0xFF. A design without the wrap would leave register 0x00 unwritten. It also reads back across the same boundary, where a design without the wrap would return the wrong value. A transfer that stops after a single high byte must leave its register untouched, which catches a design that writes each byte as it arrives. A foreign address followed by further bytes must get no acknowledge and cause no write, which catches a slave that keeps decoding after a mismatch. A read that ends with a no-acknowledge, followed by another byte of clocks, must come back all ones, which catches a slave that keeps driving data. A monitor flags any change of the SDA drive while SCL is high, which catches output timing tied to the wrong clock edge.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int IDX_W  = BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_IDX, ST_IDX_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_sync_edge.sv
`timescale 1ns/1ps
module twi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twi_reg_bank.sv
`timescale 1ns/1ps
module twi_reg_bank
  import twi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [REG_W-1:0] host_wdata_i,
  output logic [REG_W-1:0] host_rdata_o
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG*REG_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] q;
    // host port wins a same-cycle collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (host_we_i && host_addr_i == IDX_W'(g)) q <= host_wdata_i;
      else if (bus_we_i && bus_addr_i == IDX_W'(g)) q <= bus_wdata_i;
    end
    assign flat[g*REG_W +: REG_W] = q;
  end

  assign bus_rdata_o  = flat[int'(bus_addr_i)*REG_W +: REG_W];
  assign host_rdata_o = flat[int'(host_addr_i)*REG_W +: REG_W];
endmodule

// File: rtl/twi_slave_fsm.sv
`timescale 1ns/1ps
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hBA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             sda_oe_o
);
  twi_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, hi_hold;
  logic              rw, lo_ph, mack;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_bit;

  assign tx_byte = lo_ph ? rd_data_i[BYTE_W-1:0] : rd_data_i[REG_W-1:BYTE_W];
  assign tx_bit  = tx_byte[~bit_cnt[2:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      hi_hold   <= '0;
      rw        <= 1'b0;
      lo_ph     <= 1'b0;
      mack      <= 1'b0;
      idx_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (wr_en_o) idx_o <= idx_o + 1'b1;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        lo_ph    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR[7:1]) begin
                    rw       <= shreg[0];
                    sda_oe_o <= 1'b1;
                    state    <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_IDX: begin
                  idx_o    <= shreg;
                  lo_ph    <= 1'b0;
                  sda_oe_o <= 1'b1;
                  state    <= ST_IDX_ACK;
                end
                default: begin
                  if (!lo_ph) hi_hold <= shreg;
                  else        wr_data_o <= {hi_hold, shreg};
                  sda_oe_o <= 1'b1;
                  state    <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state    <= rw ? ST_RDATA : ST_IDX;
          end
          ST_IDX_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WDATA;
            wr_en_o  <= lo_ph;  // commit once the low byte is acknowledged
            lo_ph    <= ~lo_ph;
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              bit_cnt  <= '0;
              sda_oe_o <= 1'b0;
              state    <= ST_RDATA_ACK;
            end else if (!scl_i && bit_cnt < 4'd8) begin
              sda_oe_o <= ~tx_bit;
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                state <= ST_RDATA;
                if (lo_ph) idx_o <= idx_o + 1'b1;
                lo_ph <= ~lo_ph;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_reg16_slave.sv
`timescale 1ns/1ps
module twi_reg16_slave
  import twi_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR    = 8'hBA,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             host_we_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [REG_W-1:0] host_wdata_i,
  output logic [REG_W-1:0] host_rdata_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_cond, stop_cond;
  logic             bus_we;
  logic [IDX_W-1:0] bus_idx;
  logic [REG_W-1:0] bus_wdata, bus_rdata;

  twi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_cond), .stop_o(stop_cond)
  );

  twi_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_cond), .stop_i(stop_cond), .rd_data_i(bus_rdata),
    .wr_en_o(bus_we), .idx_o(bus_idx), .wr_data_o(bus_wdata), .sda_oe_o
  );

  twi_reg_bank u_bank (
    .clk_i, .rst_ni,
    .bus_we_i(bus_we), .bus_addr_i(bus_idx), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o
  );
endmodule

// File: rtl/twi_reg16_slave_chk.sv
`timescale 1ns/1ps
module twi_reg16_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start_cond,
  input logic       stop_cond,
  input logic       sda_oe_o,
  input logic       bus_we,
  input logic [7:0] bus_idx
);
  assert_drive_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  assert_start_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cond |=> !sda_oe_o);

  assert_stop_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cond |=> !sda_oe_o);

  assert_idx_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we |=> bus_idx == 8'($past(bus_idx) + 8'd1));
endmodule

bind twi_reg16_slave twi_reg16_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_cond(start_cond),
  .stop_cond(stop_cond), .sda_oe_o(sda_oe_o), .bus_we(bus_we), .bus_idx(bus_idx)
);

// File: tb/twi_reg16_slave_tb.sv
`timescale 1ns/1ps
module twi_reg16_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        sda_line;
  int          n_chk = 0, n_fail = 0, r9_viol = 0;
  bit          done = 1'b0;
  logic        oe_q = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  twi_reg16_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata)
  );

  // R9 monitor: drive changes seen while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_q && scl_m) r9_viol++;
    oe_q = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b; wq; scl_m = 1'b1; wq; s = sda_line; wq; scl_m = 1'b0; wq;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, s);
      d = {d[6:0], s};
    end
    bit_xfer(~mack, s);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic host_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    host_addr = a;
    #1;
    check(req, {16'h0, host_rdata}, {16'h0, exp});
  endtask

  task automatic t_reset;
    check("R10 reset sda_oe", {31'h0, sda_oe}, 32'h0);
    host_chk("R10 reset reg 0x10", 8'h10, 16'h0000);
  endtask

  task automatic t_single_write;
    logic a0, a1, a2, a3;
    bus_start;
    wr_byte(8'hBA, a0); wr_byte(8'h10, a1);
    wr_byte(8'hA5, a2); wr_byte(8'h5A, a3);
    bus_stop;
    check("R2 address ack", {31'h0, a0}, 32'h1);
    check("R4 index ack", {31'h0, a1}, 32'h1);
    check("R4 data acks", {30'h0, a2, a3}, 32'h3);
    host_chk("R5 write 0x10", 8'h10, 16'hA55A);
    check("R11 released after stop", {31'h0, sda_oe}, 32'h0);
  endtask

  task automatic t_wrap_write;
    logic a;
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'hFE, a);
    wr_byte(8'h0A, a); wr_byte(8'h0B, a);
    wr_byte(8'hC0, a); wr_byte(8'hDE, a);
    wr_byte(8'h7E, a); wr_byte(8'h57, a);
    bus_stop;
    host_chk("R6 burst 0xFE", 8'hFE, 16'h0A0B);
    host_chk("R6 burst 0xFF", 8'hFF, 16'hC0DE);
    host_chk("R6 wrap to 0x00", 8'h00, 16'h7E57);
  endtask

  task automatic t_partial;
    logic a;
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'h20, a); wr_byte(8'h99, a);
    bus_stop;
    host_chk("R5 lone high byte dropped", 8'h20, 16'h0000);
  endtask

  task automatic t_foreign;
    logic a0, a1, a2;
    bus_start;
    wr_byte(8'h42, a0); wr_byte(8'h30, a1); wr_byte(8'h99, a2); wr_byte(8'h88, a2);
    bus_stop;
    check("R3 no address ack", {31'h0, a0}, 32'h0);
    check("R3 no later acks", {30'h0, a1, a2}, 32'h0);
    host_chk("R3 nothing written", 8'h30, 16'h0000);
  endtask

  task automatic t_read;
    logic a;
    logic [7:0] d0, d1, d2, d3, d4;
    host_wr(8'h40, 16'h1234);
    host_wr(8'h41, 16'hBEEF);
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'h40, a);
    bus_start;
    wr_byte(8'hBB, a);
    check("R2 read address ack", {31'h0, a}, 32'h1);
    rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b1, d2); rd_byte(1'b0, d3);
    check("R7 read bytes", {d0, d1, d2, d3}, 32'h1234BEEF);
    rd_byte(1'b0, d4);
    check("R8 released after nack", {24'h0, d4}, 32'h000000FF);
    bus_stop;
  endtask

  task automatic t_read_wrap;
    logic a;
    logic [7:0] d0, d1, d2, d3;
    host_wr(8'hFF, 16'hCAFE);
    host_wr(8'h00, 16'h0102);
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'hFF, a);
    bus_start;
    wr_byte(8'hBB, a);
    rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b1, d2); rd_byte(1'b0, d3);
    bus_stop;
    check("R6 read wrap", {d0, d1, d2, d3}, 32'hCAFE0102);
  endtask

  task automatic t_restart_write;
    logic a;
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'h50, a); wr_byte(8'h11, a); wr_byte(8'h11, a);
    bus_start;
    wr_byte(8'hBA, a); wr_byte(8'h51, a); wr_byte(8'h22, a); wr_byte(8'h22, a);
    bus_stop;
    host_chk("R11 first transfer kept", 8'h50, 16'h1111);
    host_chk("R11 second transfer", 8'h51, 16'h2222);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    wq;
    t_single_write;
    t_wrap_write;
    t_partial;
    t_foreign;
    t_read;
    t_read_wrap;
    t_restart_write;
    check("R9 drive changes with SCL high", r9_viol, 32'h0);
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run;
    end
  end
endmodule